// File: doc/BRIEF.md
# Serial Configuration Register Port

This block lets an external controller fill four 24-bit control registers over three wires: a serial clock, a serial data line and a load strobe. Bits enter a 24-bit shift register on each rising serial-clock edge, most significant bit first. A rising edge on the load strobe copies the whole word into one of four holding registers. The two least significant bits of that word select which one. The other 22 bits are written together with them.

The three serial wires are asynchronous to the system clock. Each passes through a two-flop synchroniser, and edges are found on the synchronised copies. A synchronous chip-enable input switches the port off. While it is low, the port ignores every serial wire and empties the shift register. The block presents the four register words and a one-cycle update strobe per register. It also presents the two 7-bit output-power codes that the modulation register carries, each split into a 2-bit range and a 5-bit level.

Top module: `cfg_serial_port`

## Requirements
- R1: After reset, all four register outputs are zero and every bit of `upd_o` is low.
- R2: On each rising edge of `ser_clk_i` (chip enable high), the bit on `ser_data_i` is shifted into the LSB end of the 24-bit shift register. The first bit sent ends up as the word's bit 23.
- R3: On a rising edge of `ser_load_i` (chip enable high), the shift-register word is written whole into the register chosen by word bits [1:0]: 0 rate, 1 divider, 2 modulation, 3 function. The other three registers keep their values.
- R4: Each write raises only the matching `upd_o` bit (index equal to the select code) for exactly one system clock cycle. That cycle is the first one in which the new value is visible.
- R5: While `chip_en_i` is low, edges on the serial clock, data and load wires have no effect: no register changes and `upd_o` stays zero.
- R6: Driving `chip_en_i` low clears the shift register. A word shifted in after chip enable returns has zeros above the bits sent since then.
- R7: A load after a number of serial clocks other than 24 still writes the 24 most recently shifted bits, taken from the shift register as it is at that moment. The shift register keeps its contents across loads.
- R8: The one-code is modulation bits [8:2], with range [8:7] and level [6:2]. The zero-code is modulation bits [15:9], with range [15:14] and level [13:9]. These four fields appear on the `pwr_*` outputs.
- R9: A register changes only in a cycle in which its update strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| chip_en_i | input | 1 | Port enable, synchronous to clk_i |
| ser_clk_i | input | 1 | Serial clock, asynchronous |
| ser_data_i | input | 1 | Serial data, asynchronous |
| ser_load_i | input | 1 | Load strobe, asynchronous |
| rate_reg_o | output | 24 | Register at select code 0 |
| div_reg_o | output | 24 | Register at select code 1 |
| mod_reg_o | output | 24 | Register at select code 2 |
| func_reg_o | output | 24 | Register at select code 3 |
| upd_o | output | 4 | One-cycle write strobe per register |
| pwr_one_range_o | output | 2 | Range field of the one-code |
| pwr_one_level_o | output | 5 | Level field of the one-code |
| pwr_zero_range_o | output | 2 | Range field of the zero-code |
| pwr_zero_level_o | output | 5 | Level field of the zero-code |

## Verification
The bench writes every select code with distinct words. It checks that bystander registers stay unchanged and that each strobe fires exactly once. A decoder off by one bit, or a strobe that stays high, would show up as a wrong register or a strobe count above one. Loads after 30 and after 10 serial clocks test whether the design takes the latest 24 bits or wrongly clears the shift register on load. Toggling every serial wire with chip enable low, then dropping chip enable in the middle of a word, exposes a port that still listens while disabled or keeps stale partial bits.

// File: rtl/cfg_serial_pkg.sv
package cfg_serial_pkg;
  localparam int unsigned WORD_W   = 24;
  localparam int unsigned NUM_REGS = 4;
  localparam int unsigned SEL_W    = $clog2(NUM_REGS);
  localparam int unsigned PWR_W    = 7;
  localparam int unsigned RANGE_W  = 2;
  localparam int unsigned LEVEL_W  = PWR_W - RANGE_W;
  localparam int unsigned PWR_ONE_LSB  = 2;
  localparam int unsigned PWR_ZERO_LSB = PWR_ONE_LSB + PWR_W;

  typedef enum logic [SEL_W-1:0] {
    SEL_RATE = 2'd0,
    SEL_DIV  = 2'd1,
    SEL_MOD  = 2'd2,
    SEL_FUNC = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/cfg_shift.sv
module cfg_shift #(
  parameter int unsigned W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         sclk_i,
  input  logic         sdata_i,
  input  logic         sload_i,
  output logic [W-1:0] word_o,
  output logic         load_o
);
  logic         sclk_d, sload_d;
  logic [W-1:0] word_q;
  logic         sclk_rise;

  assign sclk_rise = en_i & sclk_i & ~sclk_d;
  assign load_o    = en_i & sload_i & ~sload_d;
  assign word_o    = word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d  <= 1'b0;
      sload_d <= 1'b0;
      word_q  <= '0;
    end else begin
      // edge history tracks even while disabled: no false edge on re-enable
      sclk_d  <= sclk_i;
      sload_d <= sload_i;
      if (!en_i)          word_q <= '0;
      else if (sclk_rise) word_q <= {word_q[W-2:0], sdata_i};
    end
  end
endmodule

// File: rtl/cfg_latch_bank.sv
module cfg_latch_bank #(
  parameter int unsigned W = 24,
  parameter int unsigned N = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [W-1:0]        word_i,
  output logic [N-1:0][W-1:0] regs_o,
  output logic [N-1:0]        upd_o
);
  localparam int unsigned AW = $clog2(N);

  for (genvar i = 0; i < N; i++) begin : g_reg
    logic hit;
    assign hit = load_i && (word_i[AW-1:0] == AW'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regs_o[i] <= '0;
        upd_o[i]  <= 1'b0;
      end else begin
        upd_o[i] <= hit;
        if (hit) regs_o[i] <= word_i;
      end
    end
  end
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
  import cfg_serial_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 chip_en_i,
  input  logic                 ser_clk_i,
  input  logic                 ser_data_i,
  input  logic                 ser_load_i,
  output logic [WORD_W-1:0]    rate_reg_o,
  output logic [WORD_W-1:0]    div_reg_o,
  output logic [WORD_W-1:0]    mod_reg_o,
  output logic [WORD_W-1:0]    func_reg_o,
  output logic [NUM_REGS-1:0]  upd_o,
  output logic [RANGE_W-1:0]   pwr_one_range_o,
  output logic [LEVEL_W-1:0]   pwr_one_level_o,
  output logic [RANGE_W-1:0]   pwr_zero_range_o,
  output logic [LEVEL_W-1:0]   pwr_zero_level_o
);
  logic [2:0]                      sync_q;
  logic [WORD_W-1:0]               word;
  logic                            load;
  logic [NUM_REGS-1:0][WORD_W-1:0] regs;
  logic [PWR_W-1:0]                pwr_one, pwr_zero;

  cfg_sync #(.W(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({ser_load_i, ser_data_i, ser_clk_i}),
    .q_o    (sync_q)
  );

  cfg_shift #(.W(WORD_W)) i_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (chip_en_i),
    .sclk_i  (sync_q[0]),
    .sdata_i (sync_q[1]),
    .sload_i (sync_q[2]),
    .word_o  (word),
    .load_o  (load)
  );

  cfg_latch_bank #(.W(WORD_W), .N(NUM_REGS)) i_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .word_i (word),
    .regs_o (regs),
    .upd_o  (upd_o)
  );

  assign rate_reg_o = regs[SEL_RATE];
  assign div_reg_o  = regs[SEL_DIV];
  assign mod_reg_o  = regs[SEL_MOD];
  assign func_reg_o = regs[SEL_FUNC];

  assign pwr_one  = mod_reg_o[PWR_ONE_LSB  +: PWR_W];
  assign pwr_zero = mod_reg_o[PWR_ZERO_LSB +: PWR_W];

  assign pwr_one_range_o  = pwr_one[PWR_W-1 -: RANGE_W];
  assign pwr_one_level_o  = pwr_one[LEVEL_W-1:0];
  assign pwr_zero_range_o = pwr_zero[PWR_W-1 -: RANGE_W];
  assign pwr_zero_level_o = pwr_zero[LEVEL_W-1:0];
endmodule

// File: rtl/cfg_serial_port_chk.sv
module cfg_serial_port_chk
  import cfg_serial_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                chip_en_i,
  input logic [WORD_W-1:0]   rate_reg_o,
  input logic [WORD_W-1:0]   div_reg_o,
  input logic [WORD_W-1:0]   mod_reg_o,
  input logic [WORD_W-1:0]   func_reg_o,
  input logic [NUM_REGS-1:0] upd_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) assert_reset_R1: assert (upd_o == '0 && rate_reg_o == '0 && func_reg_o == '0);
  end

  assert_upd_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(upd_o));

  assert_upd_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o != '0 |=> upd_o == '0);

  assert_ce_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(chip_en_i) |-> upd_o == '0);

  assert_sel_rate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o[SEL_RATE] |-> rate_reg_o[SEL_W-1:0] == SEL_RATE);
  assert_sel_div_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o[SEL_DIV] |-> div_reg_o[SEL_W-1:0] == SEL_DIV);
  assert_sel_mod_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o[SEL_MOD] |-> mod_reg_o[SEL_W-1:0] == SEL_MOD);
  assert_sel_func_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o[SEL_FUNC] |-> func_reg_o[SEL_W-1:0] == SEL_FUNC);

  assert_hold_rate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_o[SEL_RATE] |-> $stable(rate_reg_o));
  assert_hold_div_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_o[SEL_DIV] |-> $stable(div_reg_o));
  assert_hold_mod_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_o[SEL_MOD] |-> $stable(mod_reg_o));
  assert_hold_func_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_o[SEL_FUNC] |-> $stable(func_reg_o));
endmodule

bind cfg_serial_port cfg_serial_port_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .chip_en_i  (chip_en_i),
  .rate_reg_o (rate_reg_o),
  .div_reg_o  (div_reg_o),
  .mod_reg_o  (mod_reg_o),
  .func_reg_o (func_reg_o),
  .upd_o      (upd_o)
);

// File: tb/test_cfg_serial_port.sv
module test_cfg_serial_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce = 1'b0;
  logic        sclk = 1'b0, sdat = 1'b0, sload = 1'b0;
  logic [23:0] rate_r, div_r, mod_r, func_r;
  logic [3:0]  upd;
  logic [1:0]  one_rng, zero_rng;
  logic [4:0]  one_lvl, zero_lvl;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int upd_cnt [4];
  logic [23:0] exp_reg [4];
  logic [23:0] sr_model = '0;

  always #2 clk = ~clk;

  cfg_serial_port i_cfg_serial_port (
    .clk_i (clk), .rst_ni (rst_n), .chip_en_i (ce),
    .ser_clk_i (sclk), .ser_data_i (sdat), .ser_load_i (sload),
    .rate_reg_o (rate_r), .div_reg_o (div_r), .mod_reg_o (mod_r), .func_reg_o (func_r),
    .upd_o (upd),
    .pwr_one_range_o (one_rng), .pwr_one_level_o (one_lvl),
    .pwr_zero_range_o (zero_rng), .pwr_zero_level_o (zero_lvl)
  );

  initial for (int i = 0; i < 4; i++) upd_cnt[i] = 0;
  always @(posedge clk) for (int i = 0; i < 4; i++) if (upd[i] === 1'b1) upd_cnt[i] <= upd_cnt[i] + 1;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(logic [31:0] val, int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdat = val[i];
      wait_clk(4);
      sclk = 1'b1;
      if (ce) sr_model = {sr_model[22:0], val[i]};
      wait_clk(4);
      sclk = 1'b0;
      wait_clk(4);
    end
  endtask

  task automatic pulse_load();
    sload = 1'b1;
    if (ce) exp_reg[sr_model[1:0]] = sr_model;
    wait_clk(4);
    sload = 1'b0;
    wait_clk(6);
  endtask

  task automatic check_regs(string req);
    check({req, " rate"}, {8'h0, rate_r}, {8'h0, exp_reg[0]});
    check({req, " div"},  {8'h0, div_r},  {8'h0, exp_reg[1]});
    check({req, " mod"},  {8'h0, mod_r},  {8'h0, exp_reg[2]});
    check({req, " func"}, {8'h0, func_r}, {8'h0, exp_reg[3]});
  endtask

  task automatic check_counts(string req, int c0, int c1, int c2, int c3);
    check({req, " upd0"}, upd_cnt[0], c0);
    check({req, " upd1"}, upd_cnt[1], c1);
    check({req, " upd2"}, upd_cnt[2], c2);
    check({req, " upd3"}, upd_cnt[3], c3);
  endtask

  // R1
  task automatic test_reset();
    for (int i = 0; i < 4; i++) exp_reg[i] = '0;
    check_regs("R1 reset");
    check("R1 upd", {28'h0, upd}, 0);
    check_counts("R1", 0, 0, 0, 0);
  endtask

  // R2 R3 R4 R9: each select code, bystanders untouched, one strobe each
  task automatic test_select();
    shift_bits(32'hA5C3F0, 24); pulse_load();
    check_regs("R2 R3 sel0");
    check_counts("R4 sel0", 1, 0, 0, 0);
    shift_bits(32'h12_3459, 24); pulse_load();
    check_regs("R3 sel1");
    check_counts("R4 sel1", 1, 1, 0, 0);
    shift_bits(32'h00_FFFE, 24); pulse_load();
    check_regs("R3 sel2");
    check_counts("R4 sel2", 1, 1, 1, 0);
    shift_bits(32'h80_0003, 24); pulse_load();
    check_regs("R3 R9 sel3");
    check_counts("R4 sel3", 1, 1, 1, 1);
    check("R2 msb first", {8'h0, func_r}, 32'h0080_0003);
  endtask

  // R7: long and short frames
  task automatic test_odd_length();
    shift_bits(32'h3F_BEEF_01 >> 8, 6);
    shift_bits(32'h5A_6B7D, 24); pulse_load();
    check("R7 long frame", {8'h0, div_r}, 32'h005A_6B7D);
    shift_bits(32'h2AE, 10); pulse_load();
    check("R7 short frame", {8'h0, mod_r}, {8'h0, 14'h2B7D, 10'h2AE});
    check_regs("R7 regs");
    check_counts("R7", 1, 2, 2, 1);
  endtask

  // R5 R6
  task automatic test_chip_enable();
    ce = 1'b0; wait_clk(3);
    shift_bits(32'hFFFFFF, 24);
    pulse_load();
    shift_bits(32'h000001, 24);
    pulse_load();
    check_regs("R5 disabled");
    check_counts("R5", 1, 2, 2, 1);
    ce = 1'b1; wait_clk(3);
    shift_bits(32'hFFF, 12);
    ce = 1'b0; sr_model = '0; wait_clk(3);
    ce = 1'b1; wait_clk(3);
    shift_bits(32'h9C3, 12); pulse_load();
    check("R6 cleared", {8'h0, func_r}, 32'h0000_09C3);
    check_counts("R6", 1, 2, 2, 2);
  endtask

  // R8
  task automatic test_power();
    // one-code 7'b10_10110 at [8:2], zero-code 7'b01_01001 at [15:9]
    shift_bits({8'h0, 8'h00, 1'b0, 7'b0101001, 7'b1010110, 2'b10}, 24); pulse_load();
    check("R8 one range",  one_rng,  2'b10);
    check("R8 one level",  one_lvl,  5'b10110);
    check("R8 zero range", zero_rng, 2'b01);
    check("R8 zero level", zero_lvl, 5'b01001);
    check_regs("R8 regs");
  endtask

  initial begin
    wait_clk(5);
    test_reset();
    rst_n = 1'b1; ce = 1'b1;
    wait_clk(5);
    test_select();
    test_odd_length();
    test_chip_enable();
    test_power();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule